// File: doc/BRIEF.md
# Compare-Register Counter Output Generator

This block is a parameterised up-counter that drives one output pin from the relation between its count and two compare values. It always restarts from a programmable load value. It runs to an end limit that is picked by a select field and may be the first compare value, the second compare value, or the all-ones value of the counter width. When it reaches that limit it either reloads and keeps going or stops. Four behaviours share this one counter. Limit counting runs the count up on clock-enable ticks and toggles the output at every end of count. Event counting does the same but advances on gate edges instead of ticks. One-shot toggles the output once at the first compare value and can be restarted by a trigger. PWM holds the output low below the first compare value, drives it high up to the second, and then wraps.

The counter moves only on cycles where `tick` is high, so an upstream prescaler sets its pace. The gate line is assumed to be already filtered and synchronous. While `cnt_en` is low the count tracks the load value. Each compare match and each end of count gives a single-cycle pulse. A match can also set a sticky interrupt flag, which is cleared by writing one to it.

Top module: `cmp_counter_out`

## Requirements
- R1: While `cnt_en` is low the count follows `load_val` every cycle, no step is taken and no match or end pulse appears. When `cnt_en` rises, counting resumes from the last load value, and `out_pin` sits at its inactive level, which is `out_invert`.
- R2: In limit mode (`mode`=0) the count advances by one on each cycle with `tick` high. `limit_sel` picks the end limit: 0 selects `cmp0`, 1 selects `cmp1`, and 2 or 3 select all ones. The tick taken while the count equals the limit gives a one-cycle `end_pulse` instead of an increment, so from load L to limit M there are M−L+1 ticks per end.
- R3: At the end of count in limit or event mode, the count reloads from `load_val` if `reload_en` is 1. If `reload_en` is 0 the counter stops and holds, and no further end pulse appears.
- R4: In limit and event modes the internal output level toggles at every end of count. It starts low after the counter is enabled.
- R5: In one-shot mode (`mode`=1) the output starts low and the count runs from the load value to `cmp0`. At the end tick the output goes high and the counter stops whatever `reload_en` holds.
- R6: In one-shot mode a `sw_trig` pulse or an active gate edge restarts the count from `load_val` with the output low. It takes effect on the next clock edge and has priority over a tick in that cycle.
- R7: In PWM mode (`mode`=2) the count runs from the load value to `cmp1` and then wraps to the load value with an `end_pulse`, whatever `reload_en` holds. The output is high exactly while the count is at least `cmp0`.
- R8: In PWM mode with `pwm_gate_en` set, a gate that is not at its active level freezes the count and forces the output low. Generation resumes from the frozen count once the gate is active again.
- R9: `out_pin` is the internal output level XOR `out_invert`. `gate_pol`=0 makes a high gate active and `gate_pol`=1 makes a low gate active. A gate edge is the change into the active level.
- R10: In event mode (`mode`=3) the count advances only on active gate edges and `tick` has no effect. The end limit and reload follow R2 and R3.
- R11: `hit0_pulse` and `hit1_pulse` are one-cycle pulses. They appear in the cycle after an increment or reload leaves the count equal to `cmp0` or `cmp1` respectively.
- R12: Bit 0 of `irq_flags` is set by `hit0_pulse` and bit 1 by `hit1_pulse`, each only when the matching `irq_enable` bit is set. A flag stays set until a one is written to the same bit of `irq_clear`; if a set and a clear arrive together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable; low holds the count at the load value |
| tick | input | 1 | Clock-enable tick that paces counting |
| gate_in | input | 1 | Filtered gate line |
| sw_trig | input | 1 | Software one-shot trigger |
| load_val | input | W | Start and reload value |
| cmp0 | input | W | First compare value |
| cmp1 | input | W | Second compare value |
| mode | input | 2 | 0 limit, 1 one-shot, 2 PWM, 3 event |
| limit_sel | input | 2 | End limit select: 0 cmp0, 1 cmp1, 2/3 all ones |
| reload_en | input | 1 | Reload at end of count in limit and event modes |
| out_invert | input | 1 | Output polarity |
| gate_pol | input | 1 | Gate active level: 0 high, 1 low |
| pwm_gate_en | input | 1 | Gate starts and stops PWM |
| irq_enable | input | 2 | Per-flag interrupt enable |
| irq_clear | input | 2 | Write-one-to-clear for the flags |
| out_pin | output | 1 | Registered output pin |
| end_pulse | output | 1 | End-of-count pulse |
| hit0_pulse | output | 1 | Count reached cmp0 |
| hit1_pulse | output | 1 | Count reached cmp1 |
| irq_flags | output | 2 | Sticky interrupt flags |

## Verification
The assertions assume that `mode` and the compare values stay steady while the counter is enabled, and that the load value does not exceed the selected limit. The PWM checks also assume that `cmp0` does not change between two cycles. The stimulus follows these rules: every change of configuration is made with `cnt_en` low and is followed by a couple of idle cycles, and every swept load value lies below its limit. Gate pulses and triggers are driven one cycle wide and away from the clock edge. Gate level and polarity are changed together, so that no unintended active edge appears.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  typedef enum logic [1:0] {
    MD_LIMIT   = 2'd0,
    MD_ONESHOT = 2'd1,
    MD_PWM     = 2'd2,
    MD_EVENT   = 2'd3
  } cmpc_mode_e;

  typedef enum logic [1:0] {
    LIM_CMP0  = 2'd0,
    LIM_CMP1  = 2'd1,
    LIM_ONES  = 2'd2,
    LIM_ONES2 = 2'd3
  } cmpc_lim_e;

  localparam int unsigned NHIT = 2;
endpackage

// File: rtl/cmpc_gate_edge.sv
module cmpc_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate_in,
  input  logic gate_pol,
  output logic gate_act,
  output logic gate_edge
);
  logic act_q;

  assign gate_act  = gate_pol ? ~gate_in : gate_in;
  assign gate_edge = gate_act & ~act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= gate_act;
  end
endmodule

// File: rtl/cmpc_core.sv
module cmpc_core
  import cmpc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [1:0]   limit_sel,
  input  logic         reload_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  input  logic         pwm_gate_en,
  input  logic         gate_act,
  input  logic         gate_edge,
  input  logic         sw_trig,
  input  logic         out_invert,
  output logic         out_pin,
  output logic         end_pulse,
  output logic         hit0,
  output logic         hit1
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  cmpc_mode_e   md;
  cmpc_lim_e    lsel;
  logic [W-1:0] cnt_q, cnt_n, limit;
  logic         active_q, active_n, oraw_q, oraw_n;
  logic         eoc_n, stepped, gate_ok, trig, adv;

  assign md      = cmpc_mode_e'(mode);
  assign lsel    = cmpc_lim_e'(limit_sel);
  assign gate_ok = ~pwm_gate_en | gate_act;
  assign trig    = sw_trig | gate_edge;
  assign adv     = (md == MD_EVENT) ? gate_edge : tick;

  always_comb begin
    if (md == MD_PWM)          limit = cmp1;
    else if (md == MD_ONESHOT) limit = cmp0;
    else begin
      case (lsel)
        LIM_CMP0: limit = cmp0;
        LIM_CMP1: limit = cmp1;
        default:  limit = ALL_ONES;
      endcase
    end
  end

  always_comb begin
    cnt_n    = cnt_q;
    active_n = active_q;
    oraw_n   = oraw_q;
    eoc_n    = 1'b0;
    stepped  = 1'b0;
    if (!en) begin
      cnt_n    = load_val;
      active_n = 1'b1;
      oraw_n   = 1'b0;
    end else if (md == MD_ONESHOT && trig) begin
      cnt_n    = load_val;
      active_n = 1'b1;
      oraw_n   = 1'b0;
    end else if (active_q && adv && (md != MD_PWM || gate_ok)) begin
      if (cnt_q == limit) begin
        eoc_n = 1'b1;
        if (md == MD_PWM) begin
          cnt_n   = load_val;
          stepped = 1'b1;
        end else begin
          oraw_n = ~oraw_q;
          if (md != MD_ONESHOT && reload_en) begin
            cnt_n   = load_val;
            stepped = 1'b1;
          end else begin
            active_n = 1'b0;
          end
        end
      end else begin
        cnt_n   = cnt_q + 1'b1;
        stepped = 1'b1;
      end
    end
    if (en && md == MD_PWM) oraw_n = gate_ok && (cnt_n >= cmp0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      active_q  <= 1'b1;
      oraw_q    <= 1'b0;
      out_pin   <= 1'b0;
      end_pulse <= 1'b0;
      hit0      <= 1'b0;
      hit1      <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      active_q  <= active_n;
      oraw_q    <= oraw_n;
      out_pin   <= oraw_n ^ out_invert;
      end_pulse <= eoc_n;
      hit0      <= stepped && (cnt_n == cmp0);
      hit1      <= stepped && (cnt_n == cmp1);
    end
  end

  AST_DISABLED_LOADS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == $past(load_val))); // R1
  AST_END_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> ($past(cnt_q) == $past(limit))); // R2
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(active_q) && !active_q) |-> $stable(cnt_q)); // R3
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && md == MD_ONESHOT && $past(md == MD_ONESHOT)
     && !$past(active_q) && !active_q) |-> $stable(oraw_q)); // R5
  AST_PWM_LOW_BELOW: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && md == MD_PWM && $past(md == MD_PWM) && $stable(cmp0)
     && (cnt_q < cmp0)) |-> !oraw_q); // R7
  AST_PWM_GATED: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && md == MD_PWM && $past(md == MD_PWM)
     && $past(pwm_gate_en && !gate_act)) |-> ($stable(cnt_q) && !oraw_q)); // R8
endmodule

// File: rtl/cmpc_flags.sv
module cmpc_flags
  import cmpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NHIT-1:0] hit,
  input  logic [NHIT-1:0] irq_enable,
  input  logic [NHIT-1:0] irq_clear,
  output logic [NHIT-1:0] irq_flags
);
  for (genvar i = 0; i < NHIT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) irq_flags[i] <= 1'b0;
      else     irq_flags[i] <= (irq_flags[i] & ~irq_clear[i]) | (hit[i] & irq_enable[i]);
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (irq_flags[i] && !irq_clear[i]) |=> irq_flags[i]); // R12
  end
endmodule

// File: rtl/cmp_counter_out.sv
module cmp_counter_out
  import cmpc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         tick,
  input  logic         gate_in,
  input  logic         sw_trig,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  input  logic [1:0]   mode,
  input  logic [1:0]   limit_sel,
  input  logic         reload_en,
  input  logic         out_invert,
  input  logic         gate_pol,
  input  logic         pwm_gate_en,
  input  logic [1:0]   irq_enable,
  input  logic [1:0]   irq_clear,
  output logic         out_pin,
  output logic         end_pulse,
  output logic         hit0_pulse,
  output logic         hit1_pulse,
  output logic [1:0]   irq_flags
);
  logic gate_act, gate_edge;

  cmpc_gate_edge i_gate (
    .clk       (clk),
    .rst       (rst),
    .gate_in   (gate_in),
    .gate_pol  (gate_pol),
    .gate_act  (gate_act),
    .gate_edge (gate_edge)
  );

  cmpc_core #(.W(W)) i_core (
    .clk         (clk),
    .rst         (rst),
    .en          (cnt_en),
    .tick        (tick),
    .mode        (mode),
    .limit_sel   (limit_sel),
    .reload_en   (reload_en),
    .load_val    (load_val),
    .cmp0        (cmp0),
    .cmp1        (cmp1),
    .pwm_gate_en (pwm_gate_en),
    .gate_act    (gate_act),
    .gate_edge   (gate_edge),
    .sw_trig     (sw_trig),
    .out_invert  (out_invert),
    .out_pin     (out_pin),
    .end_pulse   (end_pulse),
    .hit0        (hit0_pulse),
    .hit1        (hit1_pulse)
  );

  cmpc_flags i_flags (
    .clk        (clk),
    .rst        (rst),
    .hit        ({hit1_pulse, hit0_pulse}),
    .irq_enable (irq_enable),
    .irq_clear  (irq_clear),
    .irq_flags  (irq_flags)
  );
endmodule

// File: tb/test_cmp_counter_out.sv
`timescale 1ns/1ps
module test_cmp_counter_out;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0, tick = 1'b0, gate_in = 1'b0, sw_trig = 1'b0;
  logic [W-1:0] load_val = '0, cmp0 = '0, cmp1 = '0;
  logic [1:0]   mode = 2'd0, limit_sel = 2'd0, irq_enable = 2'd0, irq_clear = 2'd0;
  logic         reload_en = 1'b0, out_invert = 1'b0, gate_pol = 1'b0, pwm_gate_en = 1'b0;
  logic         out_pin, end_pulse, hit0_pulse, hit1_pulse;
  logic [1:0]   irq_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_counter_out #(.W(W)) i_cmp_counter_out (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .tick(tick), .gate_in(gate_in),
    .sw_trig(sw_trig), .load_val(load_val), .cmp0(cmp0), .cmp1(cmp1),
    .mode(mode), .limit_sel(limit_sel), .reload_en(reload_en),
    .out_invert(out_invert), .gate_pol(gate_pol), .pwm_gate_en(pwm_gate_en),
    .irq_enable(irq_enable), .irq_clear(irq_clear), .out_pin(out_pin),
    .end_pulse(end_pulse), .hit0_pulse(hit0_pulse), .hit1_pulse(hit1_pulse),
    .irq_flags(irq_flags)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic park();
    @(negedge clk);
    cnt_en = 1'b0; tick = 1'b0; sw_trig = 1'b0; irq_clear = 2'd0;
    repeat (2) @(negedge clk);
  endtask

  // Counts negedges until end_pulse is seen; tick is high on every div-th edge.
  task automatic run_count(input int div, input int maxc, output int n);
    bit seen = 1'b0;
    n = 0;
    while (!seen && n < maxc) begin
      @(negedge clk);
      n++;
      if (end_pulse) seen = 1'b1;
      else tick = ((n % div) == 0);
    end
    if (!seen) n = -1;
  endtask

  task automatic count_window(input int len, output int highs, output int ends);
    highs = 0; ends = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      highs += int'(out_pin);
      ends  += int'(end_pulse);
    end
  endtask

  task automatic gate_pulse(output bit e);
    gate_in = ~gate_pol;
    @(negedge clk);
    e = end_pulse;
    gate_in = gate_pol;
  endtask

  initial begin
    int n, hi, en_cnt, lim, exp;
    bit e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: disabled reset state
    check(out_pin == 1'b0 && end_pulse == 1'b0, "R1 idle out/end", {out_pin, end_pulse}, 0);
    check(irq_flags == 2'd0, "R12 flags after reset", irq_flags, 0);
    out_invert = 1'b1;
    @(negedge clk);
    check(out_pin == 1'b1, "R9 inverted idle level", out_pin, 1);
    out_invert = 1'b0;

    // R2 R3 R4 R9: limit mode sweep with reload
    for (int sel = 0; sel < 3; sel++) begin
      for (int l = 0; l < 3; l++) begin
        for (int d = 1; d <= 4; d++) begin
          park();
          mode = 2'd0; limit_sel = 2'(sel); reload_en = 1'b1;
          load_val = W'(l);
          out_invert = (l == 1);
          cmp0 = (sel == 0) ? W'(l + d) : 8'd250;
          cmp1 = (sel == 1) ? W'(l + d) : 8'd250;
          lim = (sel == 2) ? 255 : l + d;
          @(negedge clk);
          cnt_en = 1'b1; tick = 1'b1;
          run_count(1, 400, n);
          check(n == lim - l + 1, "R2 first end tick count", n, lim - l + 1);
          check(out_pin == !(l == 1), "R4 toggle after first end", out_pin, !(l == 1));
          run_count(1, 400, n);
          check(n == lim - l + 1, "R3 reload period", n, lim - l + 1);
          check(out_pin == (l == 1), "R4 toggle after second end", out_pin, (l == 1));
        end
      end
    end
    out_invert = 1'b0;

    // R2: tick every other cycle paces the count
    for (int d = 1; d <= 5; d++) begin
      park();
      mode = 2'd0; limit_sel = 2'd0; reload_en = 1'b1; load_val = 8'd3; cmp0 = W'(3 + d);
      @(negedge clk);
      cnt_en = 1'b1; tick = 1'b1;
      run_count(2, 400, n);
      check(n == 2 * (d + 1) - 1, "R2 paced by tick", n, 2 * (d + 1) - 1);
    end

    // R3: no reload stops, R1: load captured while disabled
    park();
    mode = 2'd0; limit_sel = 2'd1; reload_en = 1'b0; load_val = 8'd10; cmp1 = 8'd14; cmp0 = 8'd200;
    @(negedge clk);
    load_val = 8'd12;
    @(negedge clk);
    cnt_en = 1'b1; tick = 1'b1;
    run_count(1, 400, n);
    check(n == 3, "R1 new load used after enable", n, 3);
    count_window(300, hi, en_cnt);
    check(en_cnt == 0, "R3 stopped no more ends", en_cnt, 0);
    check(hi == 300, "R3 output held after stop", hi, 300);

    // R5 R6: one-shot with sw and gate triggers
    park();
    mode = 2'd1; load_val = 8'd2; cmp0 = 8'd6; cmp1 = 8'd200; reload_en = 1'b1;
    gate_pol = 1'b0; gate_in = 1'b0;
    @(negedge clk);
    check(out_pin == 1'b0, "R5 one-shot starts low", out_pin, 0);
    cnt_en = 1'b1; tick = 1'b1;
    run_count(1, 100, n);
    check(n == 5, "R5 one-shot end at cmp0", n, 5);
    check(out_pin == 1'b1, "R5 one-shot toggled high", out_pin, 1);
    count_window(20, hi, en_cnt);
    check(en_cnt == 0 && hi == 20, "R5 one-shot stops despite reload", en_cnt * 100 + hi, 20);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    check(out_pin == 1'b0, "R6 sw trigger restarts low", out_pin, 0);
    run_count(1, 100, n);
    check(n == 5, "R6 retriggered run length", n, 5);
    gate_in = 1'b1; gate_pol = 1'b1;
    repeat (3) @(negedge clk);
    gate_in = 1'b0;
    @(negedge clk);
    gate_in = 1'b1;
    check(out_pin == 1'b0, "R6 R9 active-low gate trigger", out_pin, 0);
    run_count(1, 100, n);
    check(n == 5, "R6 gate retrigger run length", n, 5);
    gate_pol = 1'b0; gate_in = 1'b0;

    // R7: PWM duty sweep
    for (int c = 1; c <= 6; c++) begin
      park();
      mode = 2'd2; load_val = 8'd0; cmp0 = W'(c); cmp1 = 8'd7; reload_en = 1'b0; pwm_gate_en = 1'b0;
      @(negedge clk);
      cnt_en = 1'b1; tick = 1'b1;
      count_window(16, hi, en_cnt);
      check(hi == 2 * (8 - c), "R7 PWM high cycles", hi, 2 * (8 - c));
      check(en_cnt == 2, "R7 PWM wraps at cmp1", en_cnt, 2);
    end
    park();
    mode = 2'd2; load_val = 8'd0; cmp0 = 8'd3; cmp1 = 8'd7;
    @(negedge clk);
    cnt_en = 1'b1; tick = 1'b1;
    @(negedge clk); @(negedge clk);
    check(out_pin == 1'b0, "R7 low below cmp0", out_pin, 0);
    @(negedge clk);
    check(out_pin == 1'b1, "R7 high at cmp0", out_pin, 1);

    // R8: gated PWM
    park();
    mode = 2'd2; load_val = 8'd0; cmp0 = 8'd3; cmp1 = 8'd7; pwm_gate_en = 1'b1; gate_pol = 1'b0; gate_in = 1'b0;
    @(negedge clk);
    cnt_en = 1'b1; tick = 1'b1;
    count_window(10, hi, en_cnt);
    check(hi == 0 && en_cnt == 0, "R8 gate inactive holds", hi * 100 + en_cnt, 0);
    gate_in = 1'b1;
    run_count(1, 100, n);
    check(n == 8, "R8 gate start from frozen count", n, 8);
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    gate_in = 1'b0;
    @(negedge clk);
    check(out_pin == 1'b0, "R8 gate stop forces low", out_pin, 0);
    count_window(6, hi, en_cnt);
    check(hi == 0 && en_cnt == 0, "R8 paused stays low", hi * 100 + en_cnt, 0);
    gate_in = 1'b1;
    run_count(1, 100, n);
    check(n == 4, "R8 resumes from frozen count", n, 4);
    gate_in = 1'b0; pwm_gate_en = 1'b0;

    // R10 R4: event mode counts gate edges only
    park();
    mode = 2'd3; limit_sel = 2'd0; load_val = 8'd0; cmp0 = 8'd3; cmp1 = 8'd250; reload_en = 1'b1;
    gate_pol = 1'b0; gate_in = 1'b0;
    @(negedge clk);
    cnt_en = 1'b1; tick = 1'b1;
    count_window(20, hi, en_cnt);
    check(en_cnt == 0, "R10 ticks ignored in event mode", en_cnt, 0);
    exp = 0;
    for (int p = 1; p <= 8; p++) begin
      gate_pulse(e);
      if (e) exp = exp + p * (exp == 0 ? 1 : 100);
      @(negedge clk);
    end
    check(exp == 4 + 800, "R10 end after 4th and 8th edge", exp, 804);
    check(out_pin == 1'b0, "R4 event output toggled twice", out_pin, 0);

    // R11 R12: match pulses and sticky flags
    park();
    mode = 2'd0; limit_sel = 2'd1; load_val = 8'd0; cmp0 = 8'd2; cmp1 = 8'd5; reload_en = 1'b0;
    irq_enable = 2'b01;
    @(negedge clk);
    cnt_en = 1'b1; tick = 1'b1;
    hi = 0; en_cnt = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (hit0_pulse) hi = hi + k;
      if (hit1_pulse) en_cnt = en_cnt + k;
    end
    check(hi == 2, "R11 hit0 only at step into cmp0", hi, 2);
    check(en_cnt == 5, "R11 hit1 only at step into cmp1", en_cnt, 5);
    check(irq_flags == 2'b01, "R12 enabled flag set only", irq_flags, 1);
    repeat (5) @(negedge clk);
    check(irq_flags == 2'b01, "R12 flag sticky", irq_flags, 1);
    irq_clear = 2'b01;
    @(negedge clk);
    irq_clear = 2'b00;
    check(irq_flags == 2'b00, "R12 write one clears", irq_flags, 0);

    // R1: no pulses while disabled even if load equals a compare value
    park();
    load_val = 8'd2;
    hi = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      hi += int'(hit0_pulse) + int'(end_pulse);
    end
    check(hi == 0, "R1 no pulses while disabled", hi, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule